// File: doc/BRIEF.md
# CAN Bus-Access Initialization and Bus-Off Recovery Sequencer

This block decides when a CAN controller may take part in bus traffic. Software requests initialization mode with a write strobe and a value. The sequencer parks the controller off the bus only at a safe point: when the frame in progress ends, when an error occurs, or, after a lost arbitration, when the reception that follows has ended. When software leaves initialization mode, the bus stays disabled until the controller has seen a run of consecutive recessive bits. The controller then joins the bus in idle.

If the error counters report bus-off, hardware takes over. It drops initialization mode and blocks software writes to the init bit. It waits out a long recovery made of many runs of recessive bits, then a short power-up run. It then returns to initialization mode with the bus disabled, so that software can re-arm the controller. A status bit reports the mode actually engaged, not the mode requested.

The block has two more duties. It gates processor writes to the low control/status/mask register window, which may be written only while initialization mode is engaged. It also pulses a clear for the low-power request bit on every accepted write that sets init.

Top module: `can_init_seq`

## Requirements
- R1: After reset, initStat=1, busEn=0 and busOffState=0.
- R2: A write of init=0 while initStat=1 and busTiming is nonzero gives initStat=0 with busEn=0 from the next cycle. busEn rises on the edge of the 11th consecutive recessive bit strobe (bitTick=1, rxBit=1).
- R3: A dominant bit strobe (bitTick=1, rxBit=0) during any recessive-bit count restarts the current 11-bit run from zero.
- R4: A write of init=1 while the bus is enabled keeps busEn=1 and initStat=0 until frameDone or errEvt is seen. On the next cycle busEn=0 and initStat=1.
- R5: When arbLost is seen while waiting to enter initialization, frameDone no longer ends the wait. Only rxDone or errEvt does.
- R6: While busTiming equals 8'h00, a write of init=0 is ignored and initStat stays 1.
- R7: regWrOk=regWrReq for addresses at or above 16. For addresses 0..15 it is granted only while initStat=1.
- R8: sleepClr is 1 in the same cycle as an accepted write of init=1.
- R9: busOffIn while the bus is enabled gives busOffState=1, busEn=0 and initStat=0 on the next cycle. It overrides an init write in the same cycle.
- R10: Bus-off recovery needs 128 runs of 11 consecutive recessive bits, then one more run of 11. After that, busOffState=0, initStat=1 and busEn=0.
- R11: While busOffState=1, init writes are ignored and sleepClr stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initWrEn | input | 1 | Software write strobe for the init bit |
| initWrVal | input | 1 | Value written to the init bit |
| rxBit | input | 1 | Sampled bus bit, 1 = recessive |
| bitTick | input | 1 | One pulse per bit time |
| frameDone | input | 1 | Current reception or transmission completed |
| arbLost | input | 1 | Arbitration lost, controller now receiving |
| rxDone | input | 1 | Reception completed |
| errEvt | input | 1 | Protocol error detected |
| busOffIn | input | 1 | Bus-off reported by error counters |
| busTiming | input | 8 | Bus timing register value |
| regWrReq | input | 1 | Processor write request to register space |
| regWrAddr | input | 8 | Address of that write |
| busEn | output | 1 | Controller may take part in bus traffic |
| busOffState | output | 1 | Bus-off recovery in progress |
| initStat | output | 1 | Initialization mode engaged |
| regWrOk | output | 1 | Processor write is allowed |
| sleepClr | output | 1 | Clear pulse for the low-power request bit |

## Verification
Two functions can fall in the same cycle: a software write that sets init, and a bus-off report from the error counters. The bench drives both in one cycle while the bus is enabled. It checks that sleepClr stays low in that cycle. On the following cycle it checks that the block is in bus-off with init dropped, so that bus-off won and the write left no trace. The recovery is then timed with a dominant bit placed early in it. Ending the recovery five bits early, or one run late, both fail a check.

// File: rtl/can_init_pkg.sv
package can_init_pkg;
  typedef enum logic [2:0] {
    ST_INIT, ST_PWRUP, ST_RUN, ST_DRAIN, ST_DRAIN_RX, ST_BOFF, ST_BOFF_PWR
  } seqState_t;

  typedef struct packed {
    logic clrCnt;
    logic cntEn;
  } seqStrobe_t;
endpackage

// File: rtl/can_init_dp.sv
module can_init_dp #(
  parameter int PWR_BITS   = 11,
  parameter int REC_GROUPS = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  can_init_pkg::seqStrobe_t stb,
  input  logic                     bitTick,
  input  logic                     rxBit,
  output logic                     bitDone,
  output logic                     lastGrp
);
  localparam int BW = $clog2(PWR_BITS);
  localparam int GW = $clog2(REC_GROUPS);
  localparam logic [BW-1:0] BIT_LAST = BW'(PWR_BITS - 1);
  localparam logic [GW-1:0] GRP_LAST = GW'(REC_GROUPS - 1);

  logic [BW-1:0] bitCnt;
  logic [GW-1:0] grpCnt;

  assign bitDone = stb.cntEn && bitTick && rxBit && (bitCnt == BIT_LAST);
  assign lastGrp = (grpCnt == GRP_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrCnt) begin
      bitCnt <= '0;
      grpCnt <= '0;
    end else if (stb.cntEn && bitTick) begin
      if (!rxBit) begin
        bitCnt <= '0;
      end else if (bitCnt == BIT_LAST) begin
        bitCnt <= '0;
        grpCnt <= grpCnt + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_LAST); // R3
  AST_DOM_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cntEn && bitTick && !rxBit) |=> (bitCnt == '0)); // R3
endmodule

// File: rtl/can_init_ctrl.sv
module can_init_ctrl (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     initWrEn,
  input  logic                     initWrVal,
  input  logic                     frameDone,
  input  logic                     arbLost,
  input  logic                     rxDone,
  input  logic                     errEvt,
  input  logic                     busOffIn,
  input  logic                     timingZero,
  input  logic                     bitDone,
  input  logic                     lastGrp,
  output can_init_pkg::seqStrobe_t stb,
  output logic                     busEn,
  output logic                     busOffState,
  output logic                     initStat,
  output logic                     sleepClr
);
  import can_init_pkg::*;

  seqState_t state, nextState;
  logic wrSet, wrClr, busy;

  assign busEn       = (state == ST_RUN) || (state == ST_DRAIN) || (state == ST_DRAIN_RX);
  assign busOffState = (state == ST_BOFF) || (state == ST_BOFF_PWR);
  assign initStat    = (state == ST_INIT);
  assign busy        = busEn && busOffIn;
  assign wrSet       = initWrEn && initWrVal && !busOffState && !busy;
  assign wrClr       = initWrEn && !initWrVal && !busOffState;
  assign sleepClr    = wrSet;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_INIT:     if (wrClr && !timingZero) nextState = ST_PWRUP;
      ST_PWRUP:    if (wrSet) nextState = ST_INIT;
                   else if (bitDone) nextState = ST_RUN;
      ST_RUN:      if (busOffIn) nextState = ST_BOFF;
                   else if (wrSet) nextState = ST_DRAIN;
      ST_DRAIN:    if (busOffIn) nextState = ST_BOFF;
                   else if (errEvt) nextState = ST_INIT;
                   else if (arbLost) nextState = ST_DRAIN_RX;
                   else if (frameDone) nextState = ST_INIT;
      ST_DRAIN_RX: if (busOffIn) nextState = ST_BOFF;
                   else if (rxDone || errEvt) nextState = ST_INIT;
      ST_BOFF:     if (bitDone && lastGrp) nextState = ST_BOFF_PWR;
      ST_BOFF_PWR: if (bitDone) nextState = ST_INIT;
      default:     nextState = ST_INIT;
    endcase
  end

  always_comb begin
    stb.cntEn  = (state == ST_PWRUP) || busOffState;
    stb.clrCnt = !stb.cntEn || (nextState != state);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_INIT;
    else       state <= nextState;
  end

  AST_BOFF_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && busOffIn) |=> (busOffState && !initStat)); // R9
  AST_TIMING_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (initStat && timingZero) |=> initStat); // R6
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !initWrEn && !frameDone && !rxDone && !errEvt && !busOffIn) |=> busEn); // R4
  AST_BOFF_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busOffState && initWrEn && !bitDone) |=> !initStat); // R11
  AST_NO_SLEEP_IN_BOFF: assert property (@(posedge clk) disable iff (!rstN)
    busOffState |-> !sleepClr); // R11
endmodule

// File: rtl/can_init_seq.sv
module can_init_seq #(
  parameter int PWR_BITS   = 11,
  parameter int REC_GROUPS = 128,
  parameter int ADDR_W     = 8,
  parameter int CTRL_REGS  = 16,
  parameter int TIM_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initWrEn,
  input  logic              initWrVal,
  input  logic              rxBit,
  input  logic              bitTick,
  input  logic              frameDone,
  input  logic              arbLost,
  input  logic              rxDone,
  input  logic              errEvt,
  input  logic              busOffIn,
  input  logic [TIM_W-1:0]  busTiming,
  input  logic              regWrReq,
  input  logic [ADDR_W-1:0] regWrAddr,
  output logic              busEn,
  output logic              busOffState,
  output logic              initStat,
  output logic              regWrOk,
  output logic              sleepClr
);
  localparam logic [ADDR_W-1:0] CTRL_TOP = ADDR_W'(CTRL_REGS);

  can_init_pkg::seqStrobe_t stb;
  logic bitDone, lastGrp;

  can_init_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .initWrEn(initWrEn), .initWrVal(initWrVal),
    .frameDone(frameDone), .arbLost(arbLost), .rxDone(rxDone), .errEvt(errEvt),
    .busOffIn(busOffIn), .timingZero(busTiming == '0), .bitDone(bitDone),
    .lastGrp(lastGrp), .stb(stb), .busEn(busEn), .busOffState(busOffState),
    .initStat(initStat), .sleepClr(sleepClr)
  );

  can_init_dp #(.PWR_BITS(PWR_BITS), .REC_GROUPS(REC_GROUPS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bitTick(bitTick), .rxBit(rxBit),
    .bitDone(bitDone), .lastGrp(lastGrp)
  );

  assign regWrOk = regWrReq && ((regWrAddr >= CTRL_TOP) || initStat);

  AST_LOW_WINDOW_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrOk && regWrAddr < CTRL_TOP) |-> initStat); // R7
endmodule

// File: tb/can_init_seq_bench.sv
module can_init_seq_bench;
  logic clk = 0, rstN = 0;
  logic initWrEn = 0, initWrVal = 0, rxBit = 1, bitTick = 0;
  logic frameDone = 0, arbLost = 0, rxDone = 0, errEvt = 0, busOffIn = 0;
  logic [7:0] busTiming = 8'h00;
  logic regWrReq = 0;
  logic [7:0] regWrAddr = 0;
  logic busEn, busOffState, initStat, regWrOk, sleepClr;
  int total = 0, bad = 0;
  bit done = 0;

  // fields: address, granted while init engaged, granted while running
  localparam logic [9:0] VEC [6] = '{
    {8'h00, 1'b1, 1'b0}, {8'h07, 1'b1, 1'b0}, {8'h0F, 1'b1, 1'b0},
    {8'h10, 1'b1, 1'b1}, {8'h11, 1'b1, 1'b1}, {8'hFF, 1'b1, 1'b1}};

  always #4 clk = ~clk;

  can_init_seq u_can_init_seq (
    .clk(clk), .rstN(rstN), .initWrEn(initWrEn), .initWrVal(initWrVal),
    .rxBit(rxBit), .bitTick(bitTick), .frameDone(frameDone), .arbLost(arbLost),
    .rxDone(rxDone), .errEvt(errEvt), .busOffIn(busOffIn), .busTiming(busTiming),
    .regWrReq(regWrReq), .regWrAddr(regWrAddr), .busEn(busEn),
    .busOffState(busOffState), .initStat(initStat), .regWrOk(regWrOk),
    .sleepClr(sleepClr)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n, input logic b);
    for (int i = 0; i < n; i++) begin
      bitTick = 1; rxBit = b; cyc();
    end
    bitTick = 0; rxBit = 1;
  endtask

  task automatic wrInit(input logic v);
    initWrEn = 1; initWrVal = v; cyc(); initWrEn = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(); s = 0;
  endtask

  task automatic toRun();
    wrInit(0); ticks(11, 1);
  endtask

  task automatic tableWalk(input bit inInit);
    for (int i = 0; i < 6; i++) begin
      regWrReq = 1; regWrAddr = VEC[i][9:2]; #1;
      chk(regWrOk, inInit ? VEC[i][1] : VEC[i][0], "R7 write window");
    end
    regWrReq = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc(); rstN = 1; cyc();
    chk(initStat, 1, "R1 initStat"); chk(busEn, 0, "R1 busEn"); chk(busOffState, 0, "R1 busOff");
    tableWalk(1);
    // R6: zero timing pins init
    wrInit(0); cyc(); chk(initStat, 1, "R6 timing zero");
    busTiming = 8'h1C;
    wrInit(0);
    chk(initStat, 0, "R2 status drops"); chk(busEn, 0, "R2 bus still off");
    ticks(10, 1); ticks(1, 0); ticks(10, 1);
    chk(busEn, 0, "R3 dominant restart");
    ticks(1, 1); chk(busEn, 1, "R2 bus on after 11");
    tableWalk(0);
    // R4/R8: set init waits for frame end
    initWrEn = 1; initWrVal = 1; #1; chk(sleepClr, 1, "R8 sleep clear");
    cyc(); initWrEn = 0;
    chk(busEn, 1, "R4 waits for frame"); chk(initStat, 0, "R4 not yet engaged");
    cyc(); chk(busEn, 1, "R4 still waiting");
    pulse(frameDone); chk(busEn, 0, "R4 bus off"); chk(initStat, 1, "R4 engaged");
    // R5: arbitration lost path
    toRun(); wrInit(1); pulse(arbLost); pulse(frameDone);
    chk(busEn, 1, "R5 frameDone ignored");
    pulse(rxDone); chk(initStat, 1, "R5 engaged after rx");
    // R4: error path
    toRun(); wrInit(1); pulse(errEvt); chk(initStat, 1, "R4 error ends wait");
    // R9: bus-off beats same-cycle write
    toRun();
    busOffIn = 1; initWrEn = 1; initWrVal = 1; #1;
    chk(sleepClr, 0, "R9 no sleep clear on bus-off");
    cyc(); busOffIn = 0; initWrEn = 0;
    chk(busOffState, 1, "R9 bus-off"); chk(initStat, 0, "R9 init cleared"); chk(busEn, 0, "R9 bus off");
    // R11: writes ignored
    initWrEn = 1; initWrVal = 1; #1; chk(sleepClr, 0, "R11 sleep clear blocked");
    cyc(); initWrEn = 0; chk(initStat, 0, "R11 write ignored");
    // R10: recovery with an early dominant bit
    ticks(5, 1); ticks(1, 0); ticks(1407, 1);
    chk(busOffState, 1, "R10 recovering");
    ticks(1, 1); ticks(10, 1);
    chk(busOffState, 1, "R10 power-up running");
    ticks(1, 1);
    chk(busOffState, 0, "R10 recovery done"); chk(initStat, 1, "R10 init set"); chk(busEn, 0, "R10 bus off");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule